// File: doc/BRIEF.md
# Binary Jot Grain Developer

This block performs area amplification on a stream of binary jot rows, where each jot bit is 1 when the jot registered at least one photoelectron and 0 when it did not. One whole image row of `W` jots arrives on each cycle that `in_valid` is high. Bit x of a row is column x. Frames are `H` rows tall, and counting starts at reset: the arrivals numbered 0, H, 2H and so on, counted from zero, are row 0 of each frame. `H` must be a multiple of 16.

Two developments are available. In grain mode the frame is cut into square tiles whose size is picked at run time. Every jot of a tile becomes 1 when any jot inside that tile was hit. Larger tiles give more sensitivity and less spatial resolution. In growing mode every hit also lights the eight neighbours around it. When a colour mosaic is present, the plane-split option develops each of the four 2x2 mosaic planes separately. The planes are selected by row parity and column parity.

The block emits developed rows in input order, one for each arrival, with a fixed latency of 16 arrivals. The gray-scale step that follows is not part of this block.

Top module: `jot_developer`

## Requirements
- R1: After reset `out_valid` is 0 and `out_row` is all zero. The first 16 arrivals after reset produce no output row (`out_valid` stays 0).
- R2: From arrival 16 on, each arrival (`in_valid`=1 at a clock edge) sets `out_valid` to 1 for exactly the following cycle. `out_row` then carries the developed row of the row that arrived 16 arrivals earlier. A cycle without an arrival gives `out_valid`=0 and leaves `out_row` unchanged.
- R3: Grain mode (`mode_grow`=0, `plane_split`=0). The tile edge is 1, 2, 4 or 8 jots for `grain_sel` = 0, 1, 2 or 3. Tiles are aligned to frame row 0 and column 0. An output jot is 1 exactly when some input jot of its tile is 1.
- R4: Grain mode with `grain_sel`=0 and `plane_split`=0 reproduces the input row unchanged.
- R5: Growing mode (`mode_grow`=1, `plane_split`=0). An output jot is 1 exactly when some input jot in the 3x3 window centred on it is 1.
- R6: In growing mode, positions outside the frame count as 0. This covers columns below 0 or at W and above, and rows above row 0 or below row H-1, so rows of neighbouring frames never contribute.
- R7: Grain mode with `plane_split`=1. A tile covers 2g x 2g raw jots, where g is the tile edge from R3. An output jot takes the OR of only those jots in its tile that share its row parity and its column parity.
- R8: Growing mode with `plane_split`=1. The neighbours of a jot are the jots at row and column offsets of -2, 0 and +2 inside the frame.
- R9: `mode_grow`, `grain_sel` and `plane_split` are captured at the arrival of row 0 of each frame. Changes during a frame have no effect. Every output row is developed with the settings of the frame it belongs to.
- R10: An output row is all zero when none of the last 32 arrived rows holds a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A jot row arrives on this cycle |
| in_row | input | W | Jot row, bit x is column x |
| mode_grow | input | 1 | 0 grain tiles, 1 3x3 growing |
| grain_sel | input | 2 | Tile edge select: 1, 2, 4, 8 |
| plane_split | input | 1 | Develop the four 2x2 mosaic planes separately |
| out_valid | output | 1 | A developed row is on `out_row` |
| out_row | output | W | Developed jot row |

## Verification
The hardest state to reach from the ports is a frame boundary while rows are still in flight. Sixteen rows of the old frame are waiting to leave after the new frame's settings have already been captured, and the growing window of the old frame's last row sits right next to the new frame's first row. The stimulus reaches this state by sending frames back to back with a different mode, tile size or plane split each time. Hits are placed on the first and last rows and columns. One frame also changes its setting inputs part-way through. The expected rows come from a per-frame record of the settings that were present at each frame's row 0.

// File: rtl/jgd_pkg.sv
package jgd_pkg;
  localparam int GSEL_W  = 2;
  localparam int GMAX    = 1 << ((1 << GSEL_W) - 1);
  localparam int LAT     = 2 * GMAX;
  localparam int HD      = 2 * LAT - 1;

  typedef enum logic {DEV_GRAIN = 1'b0, DEV_GROW = 1'b1} dev_mode_e;

  typedef struct packed {
    dev_mode_e         mode;
    logic [GSEL_W-1:0] gsel;
    logic              split;
  } dev_cfg_t;

  function automatic int step_of(input logic split);
    return split ? 2 : 1;
  endfunction

  function automatic int band_of(input logic [GSEL_W-1:0] gsel, input logic split);
    return (1 << gsel) * step_of(split);
  endfunction
endpackage

// File: rtl/jgd_hist.sv
module jgd_hist #(
  parameter int W     = 32,
  parameter int DEPTH = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [W-1:0]              din,
  output logic [DEPTH-1:0][W-1:0]   hist
);
  always_ff @(posedge clk) begin
    if (rst)       hist[0] <= '0;
    else if (push) hist[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)       hist[i] <= '0;
      else if (push) hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/jgd_grain.sv
module jgd_grain
  import jgd_pkg::*;
#(
  parameter int W   = 32,
  parameter int FRW = 5
) (
  input  logic [HD-1:0][W-1:0] hist,
  input  logic [FRW-1:0]       fr,
  input  dev_cfg_t             cfg,
  output logic [W-1:0]         dev
);
  // hist[k] is frame row fr + (LAT-1-k) relative to the row being developed
  always_comb begin
    int band;
    int step;
    int off;
    int d;
    logic [W-1:0] acc;
    band = band_of(cfg.gsel, cfg.split);
    step = step_of(cfg.split);
    off  = int'(fr) & (band - 1);
    acc  = '0;
    for (int k = 0; k < HD; k++) begin
      d = LAT - 1 - k;
      if (d >= -off && d <= band - 1 - off && (d & (step - 1)) == 0)
        acc = acc | hist[k];
    end
    dev = '0;
    for (int x = 0; x < W; x++) begin
      for (int y = 0; y < W; y++) begin
        if (((x ^ y) & ~(band - 1)) == 0 && ((x ^ y) & (step - 1)) == 0 && acc[y])
          dev[x] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/jgd_grow.sv
module jgd_grow
  import jgd_pkg::*;
#(
  parameter int W   = 32,
  parameter int H   = 32,
  parameter int FRW = 5
) (
  input  logic [HD-1:0][W-1:0] hist,
  input  logic [FRW-1:0]       fr,
  input  dev_cfg_t             cfg,
  output logic [W-1:0]         dev
);
  always_comb begin
    int step;
    int rowi;
    logic [W-1:0] vert;
    step = step_of(cfg.split);
    vert = '0;
    for (int t = -1; t <= 1; t++) begin
      rowi = int'(fr) + t * step;
      if (rowi >= 0 && rowi < H)
        vert = vert | hist[LAT - 1 - t * step];
    end
    dev = vert;
    for (int x = 0; x < W; x++) begin
      if (x >= step && vert[x - step])    dev[x] = 1'b1;
      if (x + step < W && vert[x + step]) dev[x] = 1'b1;
    end
  end
endmodule

// File: rtl/jot_developer.sv
module jot_developer
  import jgd_pkg::*;
#(
  parameter int W = 32,
  parameter int H = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_row,
  input  logic          mode_grow,
  input  logic [1:0]    grain_sel,
  input  logic          plane_split,
  output logic          out_valid,
  output logic [W-1:0]  out_row
);
  localparam int FRW = $clog2(H);
  localparam int CW  = $clog2(LAT + 1);

  logic [FRW-1:0]      in_fr;
  logic [FRW-1:0]      out_fr;
  logic [CW-1:0]       fill;
  logic                primed;
  dev_cfg_t            cfg_in, cfg_cur, cfg_prev, cfg_use;
  logic [HD-1:0][W-1:0] hist;
  logic [W-1:0]        grain_dev, grow_dev, dev_sel;

  assign primed      = (fill == CW'(LAT));
  assign cfg_in.mode  = dev_mode_e'(mode_grow);
  assign cfg_in.gsel  = grain_sel;
  assign cfg_in.split = plane_split;

  // Row leaving now is LAT arrivals old; pick its frame row and settings
  always_comb begin
    if (int'(in_fr) >= LAT) begin
      out_fr  = FRW'(int'(in_fr) - LAT);
      cfg_use = cfg_cur;
    end else begin
      out_fr  = FRW'(int'(in_fr) + H - LAT);
      cfg_use = (in_fr == '0) ? cfg_cur : cfg_prev;
    end
  end

  jgd_hist #(.W(W), .DEPTH(HD)) i_hist (
    .clk(clk), .rst(rst), .push(in_valid), .din(in_row), .hist(hist)
  );

  jgd_grain #(.W(W), .FRW(FRW)) i_grain (
    .hist(hist), .fr(out_fr), .cfg(cfg_use), .dev(grain_dev)
  );

  jgd_grow #(.W(W), .H(H), .FRW(FRW)) i_grow (
    .hist(hist), .fr(out_fr), .cfg(cfg_use), .dev(grow_dev)
  );

  assign dev_sel = (cfg_use.mode == DEV_GROW) ? grow_dev : grain_dev;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_fr     <= '0;
      fill      <= '0;
      cfg_cur   <= '0;
      cfg_prev  <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
    end else begin
      out_valid <= in_valid & primed;
      if (in_valid) begin
        in_fr <= (int'(in_fr) == H - 1) ? '0 : in_fr + 1'b1;
        if (!primed) fill <= fill + 1'b1;
        if (in_fr == '0) begin
          cfg_prev <= cfg_cur;
          cfg_cur  <= cfg_in;
        end
        if (primed) out_row <= dev_sel;
      end
    end
  end
endmodule

// File: rtl/jgd_checker.sv
module jgd_checker
  import jgd_pkg::*;
#(
  parameter int W = 32,
  parameter int H = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [W-1:0]  in_row,
  input logic          mode_grow,
  input logic [1:0]    grain_sel,
  input logic          plane_split,
  input logic          out_valid,
  input logic [W-1:0]  out_row
);
  localparam int AW = $clog2(LAT + 2);
  localparam int ZW = $clog2(HD + 2);

  logic [AW-1:0] arrivals;
  logic [ZW-1:0] dark_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      arrivals <= '0;
      dark_run <= '0;
    end else if (in_valid) begin
      if (int'(arrivals) <= LAT) arrivals <= arrivals + 1'b1;
      if (in_row != '0)                dark_run <= '0;
      else if (int'(dark_run) <= HD)   dark_run <= dark_run + 1'b1;
    end
  end

  assert_quiet_until_primed_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> int'(arrivals) > LAT);

  assert_output_follows_arrival_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_idle_holds_row_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_row)));

  assert_dark_window_dark_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && int'(dark_run) > HD) |-> out_row == '0);
endmodule

bind jot_developer jgd_checker #(.W(W), .H(H)) i_jgd_checker (.*);

// File: tb/test_jot_developer.sv
module test_jot_developer;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 32;
  localparam int H    = 32;
  localparam int LATR = 16;
  localparam int MAXF = 32;
  localparam int MAXR = MAXF * H;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_row = '0;
  logic         mode_grow = 1'b0;
  logic [1:0]   grain_sel = 2'd0;
  logic         plane_split = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_row;

  jot_developer #(.W(W), .H(H)) i_jot_developer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row),
    .mode_grow(mode_grow), .grain_sel(grain_sel), .plane_split(plane_split),
    .out_valid(out_valid), .out_row(out_row)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int n_arr = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [W-1:0] rows_log [MAXR];
  logic        f_mode  [MAXF];
  logic [1:0]  f_gsel  [MAXF];
  logic        f_split [MAXF];
  string       f_req   [MAXF];
  logic [W-1:0] last_out = '0;
  logic [W-1:0] pat [H];
  logic        md = 1'b0;
  logic [1:0]  gs = 2'd0;
  logic        sp = 1'b0;
  string       req = "R1";

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic jot(int f, int y, int x);
    if (y < 0 || y >= H || x < 0 || x >= W) return 1'b0;
    return rows_log[f*H + y][x];
  endfunction

  function automatic logic [W-1:0] exp_row(int r);
    int f, fr, s, b, y0, x0;
    logic [W-1:0] e;
    f  = r / H;
    fr = r % H;
    s  = f_split[f] ? 2 : 1;
    e  = '0;
    for (int x = 0; x < W; x++) begin
      if (f_mode[f]) begin
        for (int dy = -1; dy <= 1; dy++)
          for (int dx = -1; dx <= 1; dx++)
            if (jot(f, fr + dy*s, x + dx*s)) e[x] = 1'b1;
      end else begin
        b  = s * (1 << f_gsel[f]);
        y0 = fr - fr % b;
        x0 = x - x % b;
        for (int yy = y0; yy < y0 + b; yy++)
          for (int xx = x0; xx < x0 + b; xx++)
            if ((yy - fr) % s == 0 && (xx - x) % s == 0 && jot(f, yy, xx)) e[x] = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic push_row(input logic [W-1:0] r);
    int f;
    f = n_arr / H;
    in_row = r; in_valid = 1'b1;
    mode_grow = md; grain_sel = gs; plane_split = sp;
    if (n_arr % H == 0) begin
      f_mode[f] = md; f_gsel[f] = gs; f_split[f] = sp; f_req[f] = req;
    end
    rows_log[n_arr] = r;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    tests++;
    if (n_arr < LATR) begin
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1 arrival %0d: out_valid=%b expected 0", n_arr, out_valid);
      end
    end else if (out_valid !== 1'b1 || out_row !== exp_row(n_arr - LATR)) begin
      fails++;
      $display("FAIL %s (R2) row %0d: valid=%b got %h expected %h", f_req[(n_arr-LATR)/H],
               n_arr - LATR, out_valid, out_row, exp_row(n_arr - LATR));
    end
    last_out = out_row;
    n_arr++;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    in_row = ~in_row;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || out_row !== last_out) begin
      fails++;
      $display("FAIL R2 idle: valid=%b row %h expected 0 %h", out_valid, out_row, last_out);
    end
  endtask

  // kind: 0 dense, 1 sparse, 2 dark, 3 pattern buffer
  task automatic send_frame(input int kind);
    logic [W-1:0] r;
    for (int y = 0; y < H; y++) begin
      case (kind)
        0:       r = rnd();
        1:       r = rnd() & rnd() & rnd() & rnd();
        2:       r = '0;
        default: r = pat[y];
      endcase
      push_row(r);
    end
  endtask

  task automatic clear_pat();
    for (int y = 0; y < H; y++) pat[y] = '0;
  endtask

  task automatic t_reset();
    tests++;
    if (out_valid !== 1'b0 || out_row !== '0) begin
      fails++;
      $display("FAIL R1 reset: valid=%b row %h expected 0 0", out_valid, out_row);
    end
  endtask

  task automatic t_passthrough_R4();
    req = "R4"; md = 1'b0; gs = 2'd0; sp = 1'b0;
    send_frame(0);
  endtask

  task automatic t_grain_sizes_R3();
    req = "R3"; md = 1'b0; sp = 1'b0;
    for (int g = 1; g < 4; g++) begin
      gs = 2'(g);
      send_frame(1);
    end
  endtask

  task automatic t_grain_corners_R3();
    req = "R3"; md = 1'b0; sp = 1'b0; gs = 2'd3;
    clear_pat();
    pat[0][0] = 1'b1; pat[H-1][W-1] = 1'b1; pat[12][9] = 1'b1;
    send_frame(3);
  endtask

  task automatic t_grow_R5();
    req = "R5"; md = 1'b1; sp = 1'b0; gs = 2'd1;
    send_frame(1);
  endtask

  task automatic t_grow_border_R6();
    req = "R6"; md = 1'b1; sp = 1'b0;
    clear_pat();
    pat[0][5] = 1'b1; pat[H-1][7] = 1'b1; pat[10][0] = 1'b1; pat[20][W-1] = 1'b1;
    send_frame(3);
    clear_pat();
    pat[0][7] = 1'b1; pat[H-1][3] = 1'b1;
    send_frame(3);
  endtask

  task automatic t_split_grain_R7();
    req = "R7"; md = 1'b0; sp = 1'b1;
    gs = 2'd1; send_frame(1);
    gs = 2'd3; send_frame(1);
  endtask

  task automatic t_split_grow_R8();
    req = "R8"; md = 1'b1; sp = 1'b1;
    clear_pat();
    pat[0][0] = 1'b1; pat[9][14] = 1'b1; pat[H-1][W-2] = 1'b1;
    send_frame(3);
    send_frame(1);
  endtask

  task automatic t_midframe_R9();
    req = "R9"; md = 1'b0; gs = 2'd2; sp = 1'b0;
    for (int y = 0; y < H; y++) begin
      if (y == 7) begin md = 1'b1; gs = 2'd0; sp = 1'b1; end
      push_row(rnd() & rnd() & rnd());
    end
  endtask

  task automatic t_idle_R2();
    req = "R2"; md = 1'b1; gs = 2'd0; sp = 1'b0;
    for (int y = 0; y < H; y++) begin
      push_row(rnd() & rnd() & rnd());
      if (y % 3 == 0) idle_cycle();
      if (y % 7 == 0) begin idle_cycle(); idle_cycle(); end
    end
  endtask

  task automatic t_dark_R10();
    req = "R10"; md = 1'b0; gs = 2'd3; sp = 1'b1;
    send_frame(2);
    md = 1'b1;
    send_frame(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_passthrough_R4();
    t_grain_sizes_R3();
    t_grain_corners_R3();
    t_grow_R5();
    t_grow_border_R6();
    t_split_grain_R7();
    t_split_grow_R8();
    t_midframe_R9();
    t_idle_R2();
    t_dark_R10();
    req = "R10"; md = 1'b0; gs = 2'd0; sp = 1'b0;
    send_frame(2);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected end");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule